// File: doc/BRIEF.md
# DRAM Refresh and Wake-Up Scheduler

This block keeps an asynchronous DRAM array alive on behalf of an access sequencer. After reset it holds the array idle for a programmable power-up pause. It then runs a train of wake-up cycles and only after that reports the memory as usable. During normal operation a free-running interval timer adds one owed refresh per refresh period. The block pays these off by driving column-strobe-before-row-strobe refresh cycles itself. The memory keeps its own row pointer, so no address is produced.

The sequencer asks for the strobes with a request line and owns them while the grant is high. A grant is never taken back while the request is held, so a burst finishes. Refreshes owed during a burst are counted up to a small limit. Once that limit is reached, the next request waits until one refresh has run. A watchdog on row-strobe activity sees when the row strobe has been quiet for too long. It then drops the ready flag and replays the wake-up train before access resumes.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: From reset until the pause of PAUSE_CYC cycles has elapsed, ras_n, cas_n and we_n stay high and ready and seq_gnt stay low.
- R2: After the pause exactly WAKE_N refresh cycles run, and ready rises when the last of them completes.
- R3: Every refresh cycle the block drives lowers cas_n first, lowers ras_n T_CSR cycles later, and keeps ras_n low for T_RAS cycles. Both strobes are then high for T_RP cycles. we_n stays high whenever the block owns the strobes.
- R4: The timer adds one owed refresh every REFI_CYC cycles. The owed count saturates at MAX_OWED, and further ticks are lost.
- R5: With no request pending and at least one refresh owed, the block starts a refresh cycle, and repeats until nothing is owed.
- R6: A request made while fewer than MAX_OWED refreshes are owed is granted before any owed refresh runs.
- R7: A request made while MAX_OWED refreshes are owed is granted only after exactly one refresh cycle has run.
- R8: Once granted, seq_gnt stays high until seq_req drops. While it is high, ras_n, cas_n and we_n follow seq_ras_n, seq_cas_n and seq_we_n.
- R9: While ready is low, a request is not granted.
- R10: If IDLE_CYC cycles pass with no falling edge on ras_n, ready drops. Once the strobes are free, exactly WAKE_N refresh cycles run and ready rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_req | input | 1 | Access sequencer wants the strobes |
| seq_gnt | output | 1 | Access sequencer owns the strobes |
| ready | output | 1 | Initialization complete; memory usable |
| seq_ras_n | input | 1 | Sequencer row strobe |
| seq_cas_n | input | 1 | Sequencer column strobe |
| seq_we_n | input | 1 | Sequencer write strobe |
| ras_n | output | 1 | Row strobe to the memory |
| cas_n | output | 1 | Column strobe to the memory |
| we_n | output | 1 | Write strobe to the memory |

## Verification
The hardest condition to reach from the ports is the forced-refresh case. The owed count must reach its limit and a request must then arrive while the block is free. The stimulus finds the timer phase from the spacing of idle refreshes and holds one grant across six timer periods. It then drops the request for a single cycle and raises it again, before the block can clear the backlog. The stale-row case is reached the same way: a grant is held with quiet strobes for longer than the idle window.

// File: rtl/dram_rfr_pkg.sv
package dram_rfr_pkg;
  typedef enum logic [2:0] {
    ST_PAUSE = 3'd0,
    ST_IDLE  = 3'd1,
    ST_CSR   = 3'd2,
    ST_RAS   = 3'd3,
    ST_PRE   = 3'd4
  } rfr_state_e;
endpackage

// File: rtl/rfr_rate_timer.sv
module rfr_rate_timer #(
  parameter int REFI_CYC = 781
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int TW = $clog2(REFI_CYC + 1);
  localparam logic [TW-1:0] LAST = TW'(REFI_CYC - 1);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4: ticks are isolated pulses
  a_r4_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/rfr_backlog.sv
module rfr_backlog #(
  parameter int MAX_OWED = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic done,
  output logic owed_nz,
  output logic urgent
);
  localparam int OW = $clog2(MAX_OWED + 1);
  localparam logic [OW-1:0] OMAX = OW'(MAX_OWED);

  logic [OW-1:0] owed_q, owed_d;

  always_comb begin
    owed_d = owed_q;
    if (tick && !done) begin
      if (owed_q != OMAX) owed_d = owed_q + 1'b1;
    end else if (done && !tick) begin
      if (owed_q != '0) owed_d = owed_q - 1'b1;
    end
    owed_nz = (owed_q != '0);
    urgent  = (owed_q == OMAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owed_q <= '0;
    else        owed_q <= owed_d;
  end

  a_r4_owed_bound: assert property (@(posedge clk) disable iff (!rst_n)
    owed_q <= OMAX);
  a_r4_tick_adds: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !done && owed_q != OMAX) |=> (owed_q == $past(owed_q) + 1'b1));
endmodule

// File: rtl/rfr_idle_watch.sv
module rfr_idle_watch #(
  parameter int IDLE_CYC = 3200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_n,
  output logic stale
);
  localparam int IW = $clog2(IDLE_CYC + 1);
  localparam logic [IW-1:0] ILIM = IW'(IDLE_CYC);

  logic [IW-1:0] cnt_q, cnt_d;
  logic          ras_prev_q;
  logic          fall;

  always_comb begin
    fall  = ras_prev_q && !ras_n;
    stale = (cnt_q == ILIM);
    if (fall)       cnt_d = '0;
    else if (stale) cnt_d = cnt_q;
    else            cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      ras_prev_q <= 1'b1;
    end else begin
      cnt_q      <= cnt_d;
      ras_prev_q <= ras_n;
    end
  end

  // R10: a row-strobe fall always clears the stale flag
  a_r10_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !stale);
endmodule

// File: rtl/rfr_cbr_seq.sv
module rfr_cbr_seq
  import dram_rfr_pkg::*;
#(
  parameter int PAUSE_CYC = 25000,
  parameter int WAKE_N    = 8,
  parameter int T_CSR     = 2,
  parameter int T_RAS     = 4,
  parameter int T_RP      = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic seq_req,
  input  logic owed_nz,
  input  logic urgent,
  input  logic stale,
  output logic gnt,
  output logic ready,
  output logic own_ras_n,
  output logic own_cas_n,
  output logic rfr_done
);
  localparam int CW = $clog2(PAUSE_CYC + 1);
  localparam int WW = $clog2(WAKE_N + 1);
  localparam logic [CW-1:0] PAUSE_LD = CW'(PAUSE_CYC - 1);
  localparam logic [CW-1:0] CSR_LD   = CW'(T_CSR - 1);
  localparam logic [CW-1:0] RAS_LD   = CW'(T_RAS - 1);
  localparam logic [CW-1:0] RP_LD    = CW'(T_RP - 1);
  localparam logic [WW-1:0] WAKE_LD  = WW'(WAKE_N);

  rfr_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [WW-1:0] wake_q, wake_d;
  logic          gnt_q, gnt_d;
  logic          rdy_q, rdy_d;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    wake_d   = wake_q;
    gnt_d    = gnt_q;
    rdy_d    = rdy_q;
    rfr_done = 1'b0;
    if (stale) rdy_d = 1'b0;
    case (st_q)
      ST_PAUSE: begin
        if (cnt_q == '0) begin
          st_d   = ST_CSR;
          cnt_d  = CSR_LD;
          wake_d = WAKE_LD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_IDLE: begin
        if (gnt_q) begin
          if (!seq_req) gnt_d = 1'b0;
        end else if (stale) begin
          st_d   = ST_CSR;
          cnt_d  = CSR_LD;
          wake_d = WAKE_LD;
        end else if (owed_nz && (!seq_req || urgent)) begin
          st_d  = ST_CSR;
          cnt_d = CSR_LD;
        end else if (seq_req && rdy_q) begin
          gnt_d = 1'b1;
        end
      end
      ST_CSR: begin
        if (cnt_q == '0) begin
          st_d  = ST_RAS;
          cnt_d = RAS_LD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_RAS: begin
        if (cnt_q == '0) begin
          st_d     = ST_PRE;
          cnt_d    = RP_LD;
          rfr_done = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_PRE: begin
        if (cnt_q == '0) begin
          if (wake_q > WW'(1)) begin
            wake_d = wake_q - 1'b1;
            st_d   = ST_CSR;
            cnt_d  = CSR_LD;
          end else begin
            if (wake_q == WW'(1)) rdy_d = 1'b1;
            wake_d = '0;
            st_d   = ST_IDLE;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_PAUSE;
      cnt_q  <= PAUSE_LD;
      wake_q <= '0;
      gnt_q  <= 1'b0;
      rdy_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      wake_q <= wake_d;
      gnt_q  <= gnt_d;
      rdy_q  <= rdy_d;
    end
  end

  always_comb begin
    gnt       = gnt_q;
    ready     = rdy_q;
    own_ras_n = (st_q != ST_RAS);
    own_cas_n = !((st_q == ST_CSR) || (st_q == ST_RAS));
  end

  // R9: no grant is issued while not ready
  a_r9_no_gnt_unready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_q) |-> $past(rdy_q));
  // R7: a full backlog with free strobes starts a refresh at once
  a_r7_urgent_first: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !gnt_q && urgent) |=> (st_q == ST_CSR));
  // R8: a held request keeps its grant
  a_r8_hold_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_q && seq_req) |=> gnt_q);
  // R2: ready only rises at the end of a precharge phase
  a_r2_ready_after_wake: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_q) |-> ($past(st_q) == ST_PRE));
endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl #(
  parameter int PAUSE_CYC = 25000,
  parameter int REFI_CYC  = 781,
  parameter int IDLE_CYC  = 3200000,
  parameter int WAKE_N    = 8,
  parameter int MAX_OWED  = 8,
  parameter int T_CSR     = 2,
  parameter int T_RAS     = 4,
  parameter int T_RP      = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic seq_req,
  output logic seq_gnt,
  output logic ready,
  input  logic seq_ras_n,
  input  logic seq_cas_n,
  input  logic seq_we_n,
  output logic ras_n,
  output logic cas_n,
  output logic we_n
);
  logic [1:0] rst_sync_q;
  logic       rst_ns;
  logic       tick, done, owed_nz, urgent, stale;
  logic       gnt, own_ras_n, own_cas_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  rfr_rate_timer #(.REFI_CYC(REFI_CYC)) timer_i (
    .clk(clk), .rst_n(rst_ns), .tick(tick));

  rfr_backlog #(.MAX_OWED(MAX_OWED)) backlog_i (
    .clk(clk), .rst_n(rst_ns), .tick(tick), .done(done),
    .owed_nz(owed_nz), .urgent(urgent));

  rfr_idle_watch #(.IDLE_CYC(IDLE_CYC)) idle_i (
    .clk(clk), .rst_n(rst_ns), .ras_n(ras_n), .stale(stale));

  rfr_cbr_seq #(
    .PAUSE_CYC(PAUSE_CYC), .WAKE_N(WAKE_N),
    .T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP)
  ) seq_i (
    .clk(clk), .rst_n(rst_ns), .seq_req(seq_req), .owed_nz(owed_nz),
    .urgent(urgent), .stale(stale), .gnt(gnt), .ready(ready),
    .own_ras_n(own_ras_n), .own_cas_n(own_cas_n), .rfr_done(done));

  always_comb begin
    seq_gnt = gnt;
    if (gnt) begin
      ras_n = seq_ras_n;
      cas_n = seq_cas_n;
      we_n  = seq_we_n;
    end else begin
      ras_n = own_ras_n;
      cas_n = own_cas_n;
      we_n  = 1'b1;
    end
  end

  // R3: a row-strobe fall in an owned stretch follows a low column strobe
  a_r3_cas_first: assert property (@(posedge clk) disable iff (!rst_ns)
    (!seq_gnt && $past(!seq_gnt) && $fell(ras_n)) |-> $past(!cas_n));
  // R8: the grant only rises in answer to a request
  a_r8_gnt_needs_req: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(seq_gnt) |-> $past(seq_req));
endmodule

// File: tb/dram_refresh_ctrl_tb.sv
module dram_refresh_ctrl_tb_top;
  localparam int PAUSE = 200;
  localparam int REFI  = 300;
  localparam int IDLE  = 3000;
  localparam int WAKE  = 8;
  localparam int MAXO  = 4;
  localparam int TCSR  = 2;
  localparam int TRAS  = 4;
  localparam int TRP   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic seq_req = 1'b0;
  logic seq_ras_n = 1'b1, seq_cas_n = 1'b1, seq_we_n = 1'b1;
  logic seq_gnt, ready, ras_n, cas_n, we_n;

  int checks = 0, errors = 0;
  int cyc = 0, ref_cyc = 0, fall_cnt = 0;
  int cas_run = 0, ras_run = 0;
  logic prev_ras = 1'b1, gnt_prev = 1'b0;
  bit   done_flag = 1'b0;

  always #10 clk = ~clk;

  dram_refresh_ctrl #(
    .PAUSE_CYC(PAUSE), .REFI_CYC(REFI), .IDLE_CYC(IDLE), .WAKE_N(WAKE),
    .MAX_OWED(MAXO), .T_CSR(TCSR), .T_RAS(TRAS), .T_RP(TRP)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .seq_req(seq_req), .seq_gnt(seq_gnt),
    .ready(ready), .seq_ras_n(seq_ras_n), .seq_cas_n(seq_cas_n),
    .seq_we_n(seq_we_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n));

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Strobe monitor: R3 timing of owned cycles, counts refresh falls
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      cas_run = 0; ras_run = 0; prev_ras = 1'b1; gnt_prev = 1'b0;
    end else begin
      if (!seq_gnt && !gnt_prev) begin
        if (!we_n) check("R3", 0, 1, "we_n high while owned");
        if (prev_ras && !ras_n) begin
          fall_cnt++;
          check("R3", cas_run, TCSR, "cas lead before ras fall");
        end
        if (!prev_ras && ras_n)
          check("R3", ras_run, TRAS, "ras low width");
      end
      cas_run  = (!cas_n && ras_n) ? cas_run + 1 : 0;
      ras_run  = (!ras_n) ? ras_run + 1 : 0;
      prev_ras = ras_n;
      gnt_prev = seq_gnt;
    end
  end

  always @(posedge clk) begin
    if (cyc > 190000 && !done_flag) begin
      done_flag = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic drive_step();
    @(posedge clk); #2;
  endtask

  task automatic wait_phase(int p);
    do @(negedge clk); while (((cyc - ref_cyc) % REFI) != p);
    drive_step();
  endtask

  task automatic get_grant(string req);
    int n = 0;
    drive_step(); seq_req = 1'b1;
    do begin @(negedge clk); n++; end while (!seq_gnt && n < 100);
    check(req, int'(seq_gnt), 1, "grant arrives");
  endtask

  task automatic drop_req();
    drive_step(); seq_req = 1'b0;
  endtask

  task automatic hold_access(int n, bit toggle, string req);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      drive_step();
      seq_ras_n = !(toggle && (i % 20) < 5 && i < n - 20);
      seq_cas_n = !(toggle && (i % 20) >= 2 && (i % 20) < 4 && i < n - 20);
      seq_we_n  = !(toggle && (i % 20) == 3 && i < n - 20);
      @(negedge clk);
      if (!seq_gnt || ras_n !== seq_ras_n || cas_n !== seq_cas_n || we_n !== seq_we_n)
        bad++;
    end
    check(req, bad, 0, "strobes follow sequencer while granted");
  endtask

  task automatic idle_cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // R1, R9: reset state and quiet pause, request refused
  task automatic t_reset_pause();
    int bad = 0, gnt_seen = 0;
    @(negedge clk);
    check("R1", {ready, seq_gnt, ras_n, cas_n, we_n}, 5'b00111, "reset state");
    drive_step(); seq_req = 1'b1;
    for (int i = 0; i < PAUSE - 10; i++) begin
      @(negedge clk);
      if (!ras_n || !cas_n || !we_n || ready) bad++;
      if (seq_gnt) gnt_seen++;
    end
    check("R1", bad, 0, "strobes quiet during pause");
    check("R9", gnt_seen, 0, "no grant while not ready");
    drop_req();
  endtask

  // R2: wake-up train
  task automatic t_wake();
    int n = 0;
    while (!ready && n < 600) begin @(negedge clk); n++; end
    check("R2", int'(ready), 1, "ready rises");
    check("R2", fall_cnt, WAKE, "wake cycles before ready");
    check("R2", int'(cyc >= PAUSE + WAKE * (TCSR + TRAS + TRP)), 1, "ready not early");
  endtask

  // R4, R5: periodic refresh with no requests
  task automatic t_periodic();
    int f0 = fall_cnt, n = 0;
    while (fall_cnt == f0 && n < 1000) begin @(negedge clk); n++; end
    ref_cyc = cyc;
    f0 = fall_cnt;
    idle_cycles(REFI * 2 + REFI / 2);
    check("R5", fall_cnt - f0, 2, "refreshes over 2.5 periods");
  endtask

  // R6, R8, R5: postponed refresh, grant first, then drain
  task automatic t_postpone();
    int f0;
    wait_phase(50);
    seq_req = 1'b1;
    get_grant("R8");
    hold_access(640, 1'b1, "R8");
    drop_req();
    f0 = fall_cnt;
    get_grant("R6");
    check("R6", fall_cnt - f0, 0, "grant precedes owed refresh");
    hold_access(5, 1'b1, "R8");
    drop_req();
    idle_cycles(60);
    check("R5", fall_cnt - f0, 2, "backlog drained");
  endtask

  // R7, R4: full backlog forces one refresh ahead of a request; saturation
  task automatic t_urgent();
    int f0;
    wait_phase(50);
    seq_req = 1'b1;
    get_grant("R8");
    hold_access(1900, 1'b1, "R8");
    drop_req();
    f0 = fall_cnt;
    get_grant("R7");
    check("R7", fall_cnt - f0, 1, "one refresh before grant");
    hold_access(5, 1'b1, "R8");
    drop_req();
    idle_cycles(60);
    check("R4", fall_cnt - f0, MAXO, "owed count saturated");
  endtask

  // R10: stale row strobe forces re-wake
  task automatic t_stale();
    int f0, n = 0;
    wait_phase(20);
    seq_req = 1'b1;
    get_grant("R10");
    hold_access(IDLE + 300, 1'b0, "R8");
    check("R10", int'(ready), 0, "ready dropped after idle window");
    drop_req();
    f0 = fall_cnt;
    while (!ready && n < 600) begin @(negedge clk); n++; end
    check("R10", int'(ready), 1, "ready returns");
    check("R10", fall_cnt - f0, WAKE, "wake cycles replayed");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    t_reset_pause();
    t_wake();
    t_periodic();
    t_postpone();
    t_urgent();
    t_stale();
    done_flag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule